// File: doc/BRIEF.md
# Four-Pass Gray Level Combiner

A comparator slicer can tell only four brightness codes apart. This block gets finer shading from it by running the same picture through four passes, each taken at a different slicer reference offset. For every pixel it keeps one byte. That byte holds a 2-bit code from each pass. When a pixel address is read, the block decodes those four codes into an absolute gray level from 0 (black) to 12 (white).

A capture engine writes the slicer code for each pixel during a pass and pulses `pass_done` at the end of the pass. The block then moves to the next pass and updates the reference-control byte that sets the slicer offset. A display engine reads levels by address. A clear sequence zeroes the whole store before a new picture starts.

Top module: `gray_combiner`

## Requirements
- R1: Each pixel byte holds four 2-bit fields. The pass 0 code is in bits 1:0, pass 1 in bits 3:2, pass 2 in bits 5:4 and pass 3 in bits 7:6.
- R2: A write with `wr_en` high stores `wr_code` only into the field of the current pass. The other three fields of that pixel keep their values.
- R3: `ref_byte` equals `{pass_idx, 6'b111111}`, giving 0x3F, 0x7F, 0xBF and 0xFF for passes 0 to 3. It is 0x3F after reset. 0xFF also serves as the plain four-level setting.
- R4: `pass_idx` is 0 after reset. It steps by one, wrapping from 3 to 0, in the cycle after each `pass_done` pulse, and holds otherwise.
- R5: If any field holds code 11, the level is 12, 11, 10 or 9. The value depends on the highest-numbered pass holding 11: pass 3, 2, 1 or 0 respectively.
- R6: If no field holds 11 but one holds 10, the level is 8, 7, 6 or 5. The value depends on the highest-numbered pass holding 10: pass 3, 2, 1 or 0 respectively.
- R7: If the highest code present is 01, the level is 4, 3, 2 or 1. The value depends on the highest-numbered pass holding 01: pass 3, 2, 1 or 0 respectively.
- R8: A pixel whose four fields are all 00 reads as level 0.
- R9: `rd_level` shows the level of `rd_addr` one clock after the address is presented. If a write and a read hit the same address in the same cycle, the read returns the value from before the write.
- R10: A `clear_start` pulse while idle raises `busy` in the next cycle. `busy` stays high for exactly 2**ADDR_W cycles while every pixel is set to 0x00. Writes issued while `busy` is high are ignored.
- R11: A brighter code written in any pass raises the level at once. A darker code lowers the level only after every pass that held the brighter code has been overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_done | input | 1 | Pulse: current pass finished, advance to the next |
| clear_start | input | 1 | Pulse: zero every pixel |
| wr_en | input | 1 | Write strobe for the current pass |
| wr_addr | input | ADDR_W | Pixel address for the write |
| wr_code | input | 2 | Slicer code to store |
| rd_addr | input | ADDR_W | Pixel address to read |
| rd_level | output | 4 | Decoded gray level, 0 to 12 |
| pass_idx | output | 2 | Current pass number |
| ref_byte | output | 8 | Reference-control byte for the current pass |
| busy | output | 1 | High while a clear sweep runs |

## Verification
The assertions assume the following about the inputs:
- `clear_start` is a single-cycle pulse, issued only while `busy` is low.
- `pass_done` is a single-cycle pulse.
- Read addresses select pixels that have been cleared at least once, so no uninitialised storage reaches the decoder.

The stimulus follows these rules. It runs a full clear before any read and drives every strobe for exactly one cycle. The one exception is a deliberate write during a clear sweep, made to show that such a write is dropped.

// File: rtl/gray_pkg.sv
package gray_pkg;
  localparam int PASSES = 4;
  localparam int CODE_W = 2;
  localparam int LEVEL_W = 4;
  localparam int MAX_LEVEL = 12;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LEVEL_W-1:0] level_t;
  // packed: element 0 sits in bits 1:0, element 3 in bits 7:6
  typedef code_t [PASSES-1:0] pixel_t;
  typedef logic [$clog2(PASSES)-1:0] pass_t;
endpackage

// File: rtl/gray_field_bank.sv
module gray_field_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single-clock RAM: same-address read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gray_priority_decode.sv
module gray_priority_decode
  import gray_pkg::*;
(
  input  pixel_t pix,
  output level_t level
);
  logic found;

  always_comb begin
    level = '0;
    found = 1'b0;
    for (int c = (1 << CODE_W) - 1; c >= 1; c--) begin
      for (int p = PASSES - 1; p >= 0; p--) begin
        if (!found && pix[p] == code_t'(c)) begin
          found = 1'b1;
          level = level_t'((c - 1) * PASSES + p + 1);
        end
      end
    end
  end

  always_comb begin
    assert_level_range_R5: assert (level <= level_t'(MAX_LEVEL));
    if (pix == '0) assert_black_R8: assert (level == '0);
  end
endmodule

// File: rtl/gray_pass_ctrl.sv
module gray_pass_ctrl
  import gray_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_done,
  input  logic              clear_start,
  output pass_t             pass_idx,
  output logic [7:0]        ref_byte,
  output logic              busy,
  output logic [ADDR_W-1:0] clr_addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [5:0] REF_LOW = 6'h3F;

  pass_t pass_nxt;
  assign pass_nxt = pass_done ? pass_idx + pass_t'(1) : pass_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_idx <= '0;
      ref_byte <= {2'b00, REF_LOW};
    end else begin
      pass_idx <= pass_nxt;
      ref_byte <= {pass_nxt, REF_LOW};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      clr_addr <= '0;
    end else if (!busy) begin
      if (clear_start) begin
        busy     <= 1'b1;
        clr_addr <= '0;
      end
    end else if (clr_addr == LAST_ADDR) begin
      busy <= 1'b0;
    end else begin
      clr_addr <= clr_addr + 1'b1;
    end
  end

  assert_pass_step_R4: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> pass_idx == $past(pass_idx) + pass_t'(1));
  assert_pass_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pass_done |=> $stable(pass_idx));
  assert_ref_follows_pass_R3: assert property (@(posedge clk) disable iff (rst)
    ref_byte == {pass_idx, REF_LOW});
  assert_clear_starts_R10: assert property (@(posedge clk) disable iff (rst)
    (clear_start && !busy) |=> (busy && clr_addr == '0));
  assert_clear_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && clr_addr == LAST_ADDR) |=> !busy);
endmodule

// File: rtl/gray_combiner.sv
module gray_combiner
  import gray_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_done,
  input  logic              clear_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_code,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        rd_level,
  output logic [1:0]        pass_idx,
  output logic [7:0]        ref_byte,
  output logic              busy
);
  logic [ADDR_W-1:0] clr_addr;
  logic [ADDR_W-1:0] bank_addr;
  code_t             bank_data;
  pixel_t            pix_q;
  pass_t             pass_cur;

  gray_pass_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .pass_done(pass_done), .clear_start(clear_start),
    .pass_idx(pass_cur), .ref_byte(ref_byte), .busy(busy), .clr_addr(clr_addr)
  );

  assign pass_idx  = pass_cur;
  assign bank_addr = busy ? clr_addr : wr_addr;
  assign bank_data = busy ? code_t'(0) : wr_code;

  for (genvar p = 0; p < PASSES; p++) begin : g_bank
    logic we_p;
    assign we_p = busy || (wr_en && pass_cur == pass_t'(p));
    gray_field_bank #(.ADDR_W(ADDR_W), .DATA_W(CODE_W)) u_bank (
      .clk(clk), .we(we_p), .waddr(bank_addr), .wdata(bank_data),
      .raddr(rd_addr), .rdata(pix_q[p])
    );
  end

  gray_priority_decode u_dec (.pix(pix_q), .level(rd_level));
endmodule

// File: tb/gray_combiner_tb.sv
module gray_combiner_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 20;
  // {pixel byte (pass3 in bits 7:6 ... pass0 in bits 1:0), expected level}
  localparam logic [11:0] VEC [NV] = '{
    12'h000, 12'hC0C, 12'hFFC, 12'h30B, 12'hB0B, 12'h0CA, 12'hACA,
    12'h039, 12'h579, 12'h808, 12'h207, 12'h086, 12'h025, 12'h6A7,
    12'h404, 12'h103, 12'h042, 12'h011, 12'h153, 12'h000
  };

  logic clk = 0, rst = 1, pass_done = 0, clear_start = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_code = '0;
  logic [3:0] rd_level;
  logic [1:0] pass_idx;
  logic [7:0] ref_byte;
  logic busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gray_combiner #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .pass_done(pass_done), .clear_start(clear_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code), .rd_addr(rd_addr),
    .rd_level(rd_level), .pass_idx(pass_idx), .ref_byte(ref_byte), .busy(busy)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int c);
    wr_en = 1; wr_addr = AW'(a); wr_code = 2'(c);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step_pass();
    pass_done = 1;
    @(negedge clk);
    pass_done = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(int'(rd_level), exp, tag);
  endtask

  task automatic run_clear(input bit stray);
    int n;
    n = 0;
    clear_start = 1;
    @(negedge clk);
    clear_start = 0;
    while (busy && n < 2 * DEPTH) begin
      n++;
      if (stray && n == 100) begin
        wr_en = 1; wr_addr = AW'(1); wr_code = 2'd3;
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    chk(n, DEPTH, "R10 busy length");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(int'(busy), 0, "R10 reset busy");
    chk(int'(pass_idx), 0, "R4 reset pass");
    chk(int'(ref_byte), 'h3F, "R3 reset ref");

    run_clear(1'b0);

    // R1 R2: each pass writes its own field of every vector pixel
    for (int p = 0; p < 4; p++) begin
      chk(int'(pass_idx), p, "R4 pass index");
      chk(int'(ref_byte), (p << 6) | 'h3F, "R3 reference byte");
      for (int i = 0; i < NV; i++) wr(i, int'(VEC[i][4+2*p +: 2]));
      step_pass();
    end
    chk(int'(pass_idx), 0, "R4 wrap");
    chk(int'(ref_byte), 'h3F, "R3 wrap");

    for (int i = 0; i < NV; i++) begin
      int e;
      e = int'(VEC[i][3:0]);
      if (e >= 9) rd_chk(i, e, "R1 R2 R5 code-11 decode");
      else if (e >= 5) rd_chk(i, e, "R1 R2 R6 code-10 decode");
      else if (e >= 1) rd_chk(i, e, "R1 R2 R7 code-01 decode");
      else rd_chk(i, e, "R8 black");
    end

    // R9: same-cycle write and read return the old value, new one a cycle later
    wr_en = 1; wr_addr = AW'(30); wr_code = 2'd2; rd_addr = AW'(30);
    @(negedge clk);
    wr_en = 0;
    chk(int'(rd_level), 0, "R9 read-before-write");
    @(negedge clk);
    chk(int'(rd_level), 5, "R9 new value next cycle");
    rd_addr = AW'(1);
    @(negedge clk);
    chk(int'(rd_level), 12, "R9 one-cycle latency");

    // R10: clear with a dropped write during the sweep
    run_clear(1'b1);
    rd_chk(1, 0, "R10 stray write ignored");
    rd_chk(30, 0, "R10 cleared");
    rd_chk(2, 0, "R10 cleared");

    // R11: rise immediate, fall delayed until brighter passes rewritten
    wr(200, 3);                 // pass 0
    rd_chk(200, 9, "R11 rise");
    step_pass(); wr(200, 3);    // pass 1
    rd_chk(200, 10, "R11 rise immediate");
    step_pass(); wr(200, 0);    // pass 2
    step_pass(); wr(200, 1);    // pass 3
    rd_chk(200, 10, "R11 fall held");
    step_pass(); wr(200, 0);    // pass 0
    rd_chk(200, 10, "R11 fall held");
    step_pass(); wr(200, 0);    // pass 1
    rd_chk(200, 4, "R11 fall shown");
    chk(int'(ref_byte), 'h7F, "R3 pass 1 ref");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule